// File: doc/BRIEF.md
# Pipelined Shutter Exposure Controller

This block sets the pixel exposure of a global-shutter image sensor that runs in pipelined fashion. Each frame's exposure opens with a one-cycle pixel reset pulse and closes with a one-cycle frame-transfer request. The transfer request tells the readout sequencer to move the photodiode charge into the pixel memory and to read the frame out. While that frame is being read out, the next frame is already exposing. Software only opens and closes a capture batch. Within a batch, frames follow one another with no further command.

The exposure length comes from one of two sources. In master mode it comes from a programmed cycle count. In slave mode an external exposure pin sets it: its rising edge starts an exposure and its falling edge ends it. A transfer request is never issued while the readout sequencer reports busy. An exposure that has already expired waits for readout to go idle. A stop command lets the frame that is exposing finish its transfer and readout, and then returns the block to idle.

Top module: `pipe_exposure_ctrl`

## Requirements
- R1: After reset, pix_reset and xfer_req are low, and no pulse appears until a batch is started.
- R2: slave_mode (bit 1 of the sequencer-mode register: 0 master, 1 slave) is sampled on the edge that accepts batch_start. In master mode, a start seen high in cycle s gives the first pix_reset pulse in cycle s+2.
- R3: In master mode, exp_cycles is sampled on the edge that raises pix_reset. With readout idle, xfer_req rises exactly exp_cycles cycles after pix_reset.
- R4: In master mode, the next pix_reset follows in the cycle after each xfer_req, with no further command. Every pulse lasts one cycle, and the two pulses never coincide.
- R5: xfer_req is never high in the cycle after a cycle with ro_busy high. An expiry held off in this way issues xfer_req in the cycle after the first cycle with ro_busy low. The sequencer holds ro_busy high from the cycle in which xfer_req is high until its readout ends.
- R6: In slave mode, ext_exp passes through two synchroniser flops. A rising pin level first driven in cycle p gives pix_reset in cycle p+3. A falling level in cycle q gives xfer_req in cycle q+3, subject to R5.
- R7: In slave mode, a rising edge of ext_exp while a frame is still exposing or waiting for readout starts no exposure.
- R8: A stop during an exposure lets that frame issue its xfer_req. After it, no pix_reset follows.
- R9: A stop while a slave-mode batch waits for a rising pin edge returns the block to idle at once. Later pin pulses produce no output.
- R10: batch_start is ignored while a batch runs or while its last readout is still busy. Once the readout ends, a new start is accepted.
- R11: A change of slave_mode during a batch does not change the mode of that batch.
- R12: An exp_cycles value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batch_start | input | 1 | One-cycle request to open a capture batch |
| batch_stop | input | 1 | One-cycle request to close the batch after the current frame |
| slave_mode | input | 1 | Mode select from the sequencer-mode register bit 1 (1 = slave) |
| exp_cycles | input | EXP_W | Master-mode exposure length in clock cycles |
| ext_exp | input | 1 | Asynchronous external exposure pin (slave mode) |
| ro_busy | input | 1 | Readout sequencer busy with the previous frame |
| pix_reset | output | 1 | One-cycle pixel reset pulse, opens an exposure |
| xfer_req | output | 1 | One-cycle frame-transfer request, closes an exposure |

## Verification
Results are due at fixed distances from their causes. The first master-mode reset comes two cycles after the start cycle, and the transfer comes exp_cycles cycles after that reset. The reset that follows comes one cycle after each transfer. In slave mode, both pulses come three cycles after the pin level changes. When readout holds a transfer off, the transfer comes one cycle after busy first drops. The bench drives every input one nanosecond before a rising edge and records the cycle index of each pulse at the falling edge. It then compares each recorded index with the cycle that a bench function computes as the later of the exposure deadline and the readout release, so a pulse that arrives one cycle early or late is caught.

// File: rtl/pipe_exposure_ctrl.sv
module pipe_exposure_ctrl #(
  parameter int EXP_W  = 24,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             batch_start,
  input  logic             batch_stop,
  input  logic             slave_mode,
  input  logic [EXP_W-1:0] exp_cycles,
  input  logic             ext_exp,
  input  logic             ro_busy,
  output logic             pix_reset,
  output logic             xfer_req
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_EXPOSE, S_DRAIN} st_t;

  st_t              st;
  logic             slave_q, stop_q, ended_q;
  logic [EXP_W-1:0] cnt, len_q;
  logic [SYNC_N:0]  sync;

  wire rise     = sync[SYNC_N-1] & ~sync[SYNC_N];
  wire fall     = ~sync[SYNC_N-1] & sync[SYNC_N];
  wire stop_now = stop_q | batch_stop;
  wire expired  = (len_q == '0) || (cnt >= len_q - EXP_W'(1));
  wire done     = slave_q ? (ended_q | fall) : expired;
  wire fire     = (st == S_EXPOSE) && done && !ro_busy;
  wire trig     = (st == S_ARM) && !stop_now && (slave_q ? rise : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slave_q   <= 1'b0;
      stop_q    <= 1'b0;
      ended_q   <= 1'b0;
      cnt       <= '0;
      len_q     <= '0;
      sync      <= '0;
      pix_reset <= 1'b0;
      xfer_req  <= 1'b0;
    end else begin
      sync      <= {sync[SYNC_N-1:0], ext_exp};
      pix_reset <= 1'b0;
      xfer_req  <= 1'b0;
      if (st != S_IDLE && batch_stop) stop_q <= 1'b1;
      if (st == S_EXPOSE && !slave_q && cnt < len_q) cnt <= cnt + EXP_W'(1);
      if (st == S_EXPOSE && fall) ended_q <= 1'b1;
      case (st)
        S_IDLE: if (batch_start) begin
          slave_q <= slave_mode;
          stop_q  <= 1'b0;
          st      <= S_ARM;
        end
        S_ARM: if (stop_now) begin
          stop_q <= 1'b0;
          st     <= S_IDLE;
        end else if (trig) begin
          pix_reset <= 1'b1;
          len_q     <= exp_cycles;
          cnt       <= '0;
          ended_q   <= 1'b0;
          st        <= S_EXPOSE;
        end
        S_EXPOSE: if (fire) begin
          xfer_req <= 1'b1;
          st       <= stop_now ? S_DRAIN : S_ARM;
        end
        S_DRAIN: if (!ro_busy) begin
          stop_q <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_busy_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ro_busy |=> !xfer_req);

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_reset && xfer_req));

  p_reset_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_reset |=> !pix_reset);

  p_xfer_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req);

  p_xfer_from_expose_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> $past(st) == S_EXPOSE);

  p_slave_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_reset && slave_q) |-> $past(rise));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> (!pix_reset && !xfer_req));

  p_drain_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DRAIN |-> !pix_reset);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(slave_q));

endmodule

// File: tb/test_pipe_exposure_ctrl.sv
module test_pipe_exposure_ctrl;
  localparam int EW = 24;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          batch_start = 1'b0, batch_stop = 1'b0, slave_mode = 1'b0;
  logic          ext_exp = 1'b0, ro_busy = 1'b0;
  logic [EW-1:0] exp_cycles = '0;
  logic          pix_reset, xfer_req;

  int cyc = 0, checks = 0, fails = 0, ro_len = 1, ro_cnt = 0;
  int rst_q[$];
  int xf_q[$];

  pipe_exposure_ctrl #(.EXP_W(EW), .SYNC_N(2)) i_pipe_exposure_ctrl (
    .clk(clk), .rst_n(rst_n), .batch_start(batch_start), .batch_stop(batch_stop),
    .slave_mode(slave_mode), .exp_cycles(exp_cycles), .ext_exp(ext_exp),
    .ro_busy(ro_busy), .pix_reset(pix_reset), .xfer_req(xfer_req));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // pulse recorder and readout sequencer model
  always @(negedge clk) begin
    if (pix_reset === 1'b1) rst_q.push_back(cyc);
    if (xfer_req === 1'b1) begin
      xf_q.push_back(cyc);
      ro_cnt = ro_len;
    end else if (ro_cnt > 0) ro_cnt--;
    ro_busy = (ro_cnt > 0);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_xfer(int base, int len, int prev, int ro);
    int e = base + ((len < 1) ? 1 : len);
    if (prev >= 0 && prev + ro + 1 > e) e = prev + ro + 1;
    return e;
  endfunction

  task automatic run_master(int len, int ro, int n, bit flip, string tag);
    int s, er, ex, prev, guard;
    ro_len = ro; exp_cycles = EW'(len); slave_mode = 1'b0;
    rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; s = cyc; step(); batch_start = 1'b0;
    if (flip) slave_mode = 1'b1;
    guard = 0;
    while (rst_q.size() < n && guard < n * (len + ro + 5) + 50) begin step(); guard++; end
    batch_stop = 1'b1; step(); batch_stop = 1'b0;
    step(len + 2 * ro + 20);
    slave_mode = 1'b0;
    chk($sformatf("R8 reset count %s", tag), rst_q.size(), n);
    chk($sformatf("R8 transfer count %s", tag), xf_q.size(), n);
    er = s + 2; prev = -1;
    for (int i = 0; i < n; i++) begin
      if (i < rst_q.size()) chk($sformatf("R2/R4 reset cycle %s", tag), rst_q[i], er);
      ex = exp_xfer(er, len, prev, ro);
      if (i < xf_q.size()) chk($sformatf("R3/R5 transfer cycle %s", tag), xf_q[i], ex);
      prev = ex; er = ex + 1;
    end
  endtask

  task automatic run_slave(int ro, int n, string tag);
    int p[$];
    int q[$];
    int guard, w, prev, ex;
    ro_len = ro; slave_mode = 1'b1; ext_exp = 1'b0;
    rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; step(); batch_start = 1'b0;
    slave_mode = 1'b0; // R11: change after acceptance
    step(2);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        guard = 0;
        while (xf_q.size() < i && guard < 4 * ro + 100) begin step(); guard++; end
        step(int'($urandom % 6));
      end
      ext_exp = 1'b1; p.push_back(cyc);
      w = 6 + int'($urandom % 15);
      for (int k = 0; k < w; k++) begin
        step();
        batch_stop = (i == n - 1 && k == 3);
      end
      batch_stop = 1'b0;
      ext_exp = 1'b0; q.push_back(cyc);
    end
    step(2 * ro + 30);
    chk($sformatf("R8 slave reset count %s", tag), rst_q.size(), n);
    chk($sformatf("R8 slave transfer count %s", tag), xf_q.size(), n);
    prev = -1;
    for (int i = 0; i < n; i++) begin
      if (i < rst_q.size()) chk($sformatf("R6 slave reset cycle %s", tag), rst_q[i], p[i] + 3);
      ex = exp_xfer(q[i], 3, prev, ro);
      if (i < xf_q.size()) chk($sformatf("R6/R5 slave transfer cycle %s", tag), xf_q[i], ex);
      prev = ex;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int x0, s;
    void'($urandom(32'd90817));
    step(3);
    rst_n = 1'b1;
    step(10);
    chk("R1 pix_reset idle", int'(pix_reset), 0);
    chk("R1 xfer_req idle", int'(xfer_req), 0);
    chk("R1 no pulses", rst_q.size() + xf_q.size(), 0);

    run_master(7, 3, 3, 1'b0, "directed");
    run_master(4, 25, 4, 1'b0, "R5 readout bound");
    run_master(0, 2, 3, 1'b0, "R12 zero length");
    run_master(1, 1, 3, 1'b1, "R11 flip to slave");

    for (int b = 0; b < 8; b++)
      run_master(int'($urandom % 41), 1 + int'($urandom % 50), 2 + int'($urandom % 4),
                 1'($urandom % 2), $sformatf("R11 random %0d", b));
    for (int b = 0; b < 6; b++)
      run_slave(1 + int'($urandom % 40), 2 + int'($urandom % 3), $sformatf("random %0d", b));

    // R7: rising pin edge while a transfer is held by readout
    ro_len = 50; slave_mode = 1'b1; rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; step(); batch_start = 1'b0; step(2);
    ext_exp = 1'b1; step(6); ext_exp = 1'b0;
    while (xf_q.size() < 1) step();
    x0 = xf_q[0];
    ext_exp = 1'b1; step(5); ext_exp = 1'b0;
    step(10);
    ext_exp = 1'b1; step(3); ext_exp = 1'b0;
    step(80);
    chk("R7 resets with extra pulse", rst_q.size(), 2);
    chk("R7 held transfer cycle", (xf_q.size() > 1) ? xf_q[1] : -1, x0 + 51);
    batch_stop = 1'b1; step(); batch_stop = 1'b0; step(5);

    // R9: stop while waiting for a rising edge
    ro_len = 2; slave_mode = 1'b1; rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; step(); batch_start = 1'b0; step(3);
    batch_stop = 1'b1; step(); batch_stop = 1'b0;
    ext_exp = 1'b1; step(8); ext_exp = 1'b0; step(20);
    chk("R9 no reset after stop", rst_q.size(), 0);
    chk("R9 no transfer after stop", xf_q.size(), 0);

    // R10: start during the final readout is ignored
    ro_len = 40; slave_mode = 1'b0; exp_cycles = EW'(5); rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; step(); batch_start = 1'b0;
    while (rst_q.size() < 1) step();
    batch_stop = 1'b1; step(); batch_stop = 1'b0;
    while (xf_q.size() < 1) step();
    step(2);
    batch_start = 1'b1; step(); batch_start = 1'b0;
    step(60);
    chk("R10 start during drain ignored", rst_q.size(), 1);
    rst_q.delete(); xf_q.delete();
    batch_start = 1'b1; s = cyc; step(); batch_start = 1'b0;
    step(3);
    chk("R10 start accepted after drain", (rst_q.size() > 0) ? rst_q[0] : -1, s + 2);
    batch_stop = 1'b1; step(); batch_stop = 1'b0;
    step(100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule